// File: doc/BRIEF.md
# Supply Monitor with Battery Switchover

This block watches a digitized supply voltage and decides, cycle by cycle, how a battery-backed memory array is powered and whether it may be accessed. A 13-bit code giving the supply in millivolts arrives once per clock. From it the block produces three outputs:

- an access-inhibit output, which blocks writes, ignores the array's inputs and floats its outputs;
- a battery-connect output;
- a main-supply-connect output.

A grade input selects which pair of thresholds applies, either the tight supply tolerance or the wide one. All threshold values are parameters given in millivolts.

Every threshold crossing must be seen on a set number of consecutive samples before the state machine acts on it, so short glitches on the code are rejected. After reset the block starts in a sealed state. In that state the battery is never connected, however low the supply goes. The seal breaks the first time the supply properly exceeds the full-operation threshold, and it never returns. From then on the array is always fed by exactly one source.

Top module: `supply_guard`

## Requirements
- R1: While reset (`rstN` low) is applied, and on the clock edge that follows it, `guardState` is 0 (sealed), `protect` is 1, `batteryEn` is 0 and `supplyEn` is 1.
- R2: In the sealed state, any supply code at or below the selected full-operation threshold leaves the state sealed and `batteryEn` at 0. This includes codes below 3000.
- R3: From the sealed state, or from the protected state, a code above the full-operation threshold moves the block to the normal state (`guardState` 1). The threshold is 4750 when `gradeWide`=0. The normal state drives `protect`=0, `batteryEn`=0 and `supplyEn`=1.
- R4: In the normal state, a code at or below the protect threshold moves the block to the protected state (`guardState` 2). The protect threshold is 4500 when `gradeWide`=0. The protected state drives `protect`=1, `batteryEn`=0 and `supplyEn`=1.
- R5: With `gradeWide`=1, the full-operation threshold is 4500 and the protect threshold is 4250.
- R6: Once the seal is broken, a code below 3000 moves the block to the backup state (`guardState` 3), from either the normal or the protected state. The backup state drives `protect`=1, `batteryEn`=1 and `supplyEn`=0. If the protect and backup conditions qualify together, backup wins.
- R7: In the backup state, a code of 3000 or more moves the block to the protected state.
- R8: From the protected state, the block returns to normal only when the code exceeds the full-operation threshold. A code above the protect threshold but not above the full-operation threshold leaves it protected.
- R9: A condition must be sampled true on DEB_LEN consecutive clock edges (default 4). The state then changes on the next edge. A single sample of the condition being false restarts the count, and so does any state change.
- R10: After the seal is broken, `guardState` never returns to 0, and exactly one of `batteryEn` and `supplyEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Synchronous reset, active low |
| supplyMv | input | 13 | Supply voltage code in millivolts, unsigned |
| gradeWide | input | 1 | 0 selects the tight tolerance grade, 1 selects the wide grade |
| protect | output | 1 | Access inhibit for the array |
| batteryEn | output | 1 | Connect the backup battery to the array |
| supplyEn | output | 1 | Connect the main supply to the array |
| guardState | output | 2 | State: 0 sealed, 1 normal, 2 protected, 3 backup |

## Verification
The assertions that look back two cycles to justify a state entry assume two things. First, `gradeWide` is steady while a crossing is being qualified. Second, the supply code changes only between clock edges, so the sample a transition relied on is the one seen two edges after it. The bench changes the grade only while the state is settled and nowhere near a crossing. It drives every code on the falling edge, well away from the sampling edge, and holds each level for whole debounce windows except where a glitch is deliberately injected.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  // State encoding is visible on the guardState port.
  typedef enum logic [1:0] {
    ST_SEALED    = 2'd0,
    ST_NORMAL    = 2'd1,
    ST_PROTECTED = 2'd2,
    ST_BACKUP    = 2'd3
  } guardState_t;

  // Debounced level conditions reported by the datapath.
  typedef struct packed {
    logic runOk;     // above full-operation threshold
    logic protTrip;  // at or below protect threshold
    logic lowTrip;   // below switchover threshold
    logic highOk;    // at or above switchover threshold
  } levelFlags_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic restartDeb;
  } ctlStrobe_t;

  localparam int NUM_COND = 4;

endpackage

// File: rtl/supply_guard_dp.sv
module supply_guard_dp
  import supply_guard_pkg::*;
#(
  parameter int CODE_W    = 13,
  parameter int RUN_MV_A  = 4750,
  parameter int PROT_MV_A = 4500,
  parameter int RUN_MV_B  = 4500,
  parameter int PROT_MV_B = 4250,
  parameter int SWITCH_MV = 3000,
  parameter int DEB_LEN   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] supplyMv,
  input  logic              gradeWide,
  input  ctlStrobe_t        strobe,
  output levelFlags_t       flags
);

  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_LEN);

  logic [CODE_W-1:0] runThr;
  logic [CODE_W-1:0] protThr;
  logic [CODE_W-1:0] swThr;
  logic [NUM_COND-1:0] rawCond;
  logic [NUM_COND-1:0] qualCond;

  // Grade selects the threshold pair; switchover is common to both grades.
  always_comb begin
    runThr  = gradeWide ? CODE_W'(RUN_MV_B)  : CODE_W'(RUN_MV_A);
    protThr = gradeWide ? CODE_W'(PROT_MV_B) : CODE_W'(PROT_MV_A);
    swThr   = CODE_W'(SWITCH_MV);
  end

  always_comb begin
    rawCond[0] = supplyMv > runThr;
    rawCond[1] = supplyMv <= protThr;
    rawCond[2] = supplyMv < swThr;
    rawCond[3] = supplyMv >= swThr;
  end

  // One saturating run-length counter per condition.
  for (genvar g = 0; g < NUM_COND; g++) begin : g_deb
    logic [CNT_W-1:0] runLen;

    always_ff @(posedge clk) begin
      if (!rstN || strobe.restartDeb) begin
        runLen <= '0;
      end else if (!rawCond[g]) begin
        runLen <= '0;
      end else if (runLen != CNT_MAX) begin
        runLen <= runLen + 1'b1;
      end
    end

    assign qualCond[g] = (runLen == CNT_MAX);
  end

  assign flags.runOk    = qualCond[0];
  assign flags.protTrip = qualCond[1];
  assign flags.lowTrip  = qualCond[2];
  assign flags.highOk   = qualCond[3];

endmodule

// File: rtl/supply_guard_ctl.sv
module supply_guard_ctl
  import supply_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  levelFlags_t flags,
  output ctlStrobe_t  strobe,
  output guardState_t curState,
  output logic        protect,
  output logic        batteryEn,
  output logic        supplyEn
);

  guardState_t nxtState;

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_SEALED: begin
        if (flags.runOk) nxtState = ST_NORMAL;
      end
      ST_NORMAL: begin
        if (flags.lowTrip)       nxtState = ST_BACKUP;
        else if (flags.protTrip) nxtState = ST_PROTECTED;
      end
      ST_PROTECTED: begin
        if (flags.lowTrip)    nxtState = ST_BACKUP;
        else if (flags.runOk) nxtState = ST_NORMAL;
      end
      ST_BACKUP: begin
        if (flags.highOk) nxtState = ST_PROTECTED;
      end
      default: nxtState = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_SEALED;
    else       curState <= nxtState;
  end

  // Any state change restarts all debounce windows.
  assign strobe.restartDeb = (nxtState != curState);

  always_comb begin
    protect   = 1'b1;
    batteryEn = 1'b0;
    supplyEn  = 1'b1;
    unique case (curState)
      ST_SEALED:    begin protect = 1'b1; batteryEn = 1'b0; supplyEn = 1'b1; end
      ST_NORMAL:    begin protect = 1'b0; batteryEn = 1'b0; supplyEn = 1'b1; end
      ST_PROTECTED: begin protect = 1'b1; batteryEn = 1'b0; supplyEn = 1'b1; end
      ST_BACKUP:    begin protect = 1'b1; batteryEn = 1'b1; supplyEn = 1'b0; end
      default:      begin protect = 1'b1; batteryEn = 1'b0; supplyEn = 1'b1; end
    endcase
  end

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int CODE_W    = 13,
  parameter int RUN_MV_A  = 4750,
  parameter int PROT_MV_A = 4500,
  parameter int RUN_MV_B  = 4500,
  parameter int PROT_MV_B = 4250,
  parameter int SWITCH_MV = 3000,
  parameter int DEB_LEN   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] supplyMv,
  input  logic              gradeWide,
  output logic              protect,
  output logic              batteryEn,
  output logic              supplyEn,
  output logic [1:0]        guardState
);

  levelFlags_t flags;
  ctlStrobe_t  strobe;
  guardState_t curState;

  supply_guard_dp #(
    .CODE_W(CODE_W), .RUN_MV_A(RUN_MV_A), .PROT_MV_A(PROT_MV_A),
    .RUN_MV_B(RUN_MV_B), .PROT_MV_B(PROT_MV_B),
    .SWITCH_MV(SWITCH_MV), .DEB_LEN(DEB_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .supplyMv(supplyMv), .gradeWide(gradeWide),
    .strobe(strobe), .flags(flags)
  );

  supply_guard_ctl u_ctl (
    .clk(clk), .rstN(rstN), .flags(flags), .strobe(strobe),
    .curState(curState), .protect(protect),
    .batteryEn(batteryEn), .supplyEn(supplyEn)
  );

  assign guardState = curState;

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int CODE_W    = 13,
  parameter int RUN_MV_A  = 4750,
  parameter int RUN_MV_B  = 4500,
  parameter int SWITCH_MV = 3000
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] supplyMv,
  input logic              gradeWide,
  input logic              protect,
  input logic              batteryEn,
  input logic              supplyEn,
  input logic [1:0]        guardState
);

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (guardState != 2'd0) |-> (batteryEn ^ supplyEn)); // R10

  AST_NO_RESEAL: assert property (@(posedge clk) disable iff (!rstN)
    (guardState != 2'd0) |=> (guardState != 2'd0)); // R10

  AST_BATTERY_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(batteryEn) |-> ($past(supplyMv, 2) < CODE_W'(SWITCH_MV))); // R6

  AST_PROTECT_WHEN_OFF_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    !supplyEn |-> protect); // R6

  AST_NORMAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardState == 2'd1) |->
      ($past(supplyMv, 2) > ($past(gradeWide, 2) ? CODE_W'(RUN_MV_B) : CODE_W'(RUN_MV_A)))); // R3

  AST_SEALED_NO_BATTERY: assert property (@(posedge clk) disable iff (!rstN)
    (guardState == 2'd0) |-> !batteryEn); // R2

endmodule

bind supply_guard supply_guard_chk #(
  .CODE_W(CODE_W), .RUN_MV_A(RUN_MV_A), .RUN_MV_B(RUN_MV_B), .SWITCH_MV(SWITCH_MV)
) u_chk (
  .clk(clk), .rstN(rstN), .supplyMv(supplyMv), .gradeWide(gradeWide),
  .protect(protect), .batteryEn(batteryEn), .supplyEn(supplyEn),
  .guardState(guardState)
);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;

  localparam int DEB = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] supplyMv = '0;
  logic        gradeWide = 1'b0;
  logic        protect, batteryEn, supplyEn;
  logic [1:0]  guardState;

  int errCnt = 0;
  int chkCnt = 0;

  always #4 clk = ~clk; // 125 MHz

  supply_guard u_supply_guard (
    .clk(clk), .rstN(rstN), .supplyMv(supplyMv), .gradeWide(gradeWide),
    .protect(protect), .batteryEn(batteryEn), .supplyEn(supplyEn),
    .guardState(guardState)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectAll(input string req, input logic [1:0] st,
                           input logic p, input logic b, input logic s);
    chkCnt++;
    if (guardState !== st || protect !== p || batteryEn !== b || supplyEn !== s) begin
      errCnt++;
      $display("FAIL %s: state=%0d prot=%0b bat=%0b sup=%0b, expected state=%0d prot=%0b bat=%0b sup=%0b",
               req, guardState, protect, batteryEn, supplyEn, st, p, b, s);
    end
  endtask

  task automatic expSealed(input string req);    expectAll(req, 2'd0, 1, 0, 1); endtask
  task automatic expNormal(input string req);    expectAll(req, 2'd1, 0, 0, 1); endtask
  task automatic expProtected(input string req); expectAll(req, 2'd2, 1, 0, 1); endtask
  task automatic expBackup(input string req);    expectAll(req, 2'd3, 1, 1, 0); endtask

  task automatic doReset(input logic grade);
    @(negedge clk);
    rstN = 1'b0; supplyMv = '0; gradeWide = grade;
    tick(3);
    expSealed("R1 during reset");
    rstN = 1'b1;
    tick(1);
    expSealed("R1 after reset");
  endtask

  task automatic t_seal_and_debounce();
    supplyMv = 13'd2000; tick(20);
    expSealed("R2 low supply while sealed");
    supplyMv = 13'd4750; tick(20);
    expSealed("R2 at threshold while sealed");
    supplyMv = 13'd4800; tick(DEB);
    expSealed("R9 not yet qualified");
    tick(1);
    expNormal("R3 seal broken");
  endtask

  task automatic t_protect_band();
    supplyMv = 13'd4600; tick(20);
    expNormal("R4 band keeps normal");
    supplyMv = 13'd4500; tick(DEB + 1);
    expProtected("R4 protect at 4500");
    supplyMv = 13'd4750; tick(20);
    expProtected("R8 band keeps protected");
    supplyMv = 13'd4751; tick(DEB + 1);
    expNormal("R8 resume above run");
  endtask

  task automatic t_glitch();
    supplyMv = 13'd4400; tick(DEB - 1);
    supplyMv = 13'd4800; tick(1);
    supplyMv = 13'd4400; tick(DEB - 1);
    expNormal("R9 glitch restarts count");
    tick(2);
    expProtected("R9 protect after full window");
  endtask

  task automatic t_backup();
    supplyMv = 13'd2900; tick(DEB + 1);
    expBackup("R6 backup from protected");
    supplyMv = 13'd0; tick(30);
    expBackup("R10 stays backup, no reseal");
    supplyMv = 13'd3000; tick(DEB + 1);
    expProtected("R7 leave backup at 3000");
    supplyMv = 13'd4800; tick(DEB + 1);
    expNormal("R8 normal again");
    supplyMv = 13'd1000; tick(DEB + 1);
    expBackup("R6 direct drop from normal");
    supplyMv = 13'd4000; tick(DEB + 1);
    expProtected("R7 leave backup at 4000");
  endtask

  task automatic t_wide_grade();
    gradeWide = 1'b1;
    supplyMv = 13'd4500; tick(20);
    expProtected("R5 wide grade band at 4500");
    supplyMv = 13'd4501; tick(DEB + 1);
    expNormal("R5 wide grade run above 4500");
    supplyMv = 13'd4300; tick(20);
    expNormal("R5 wide grade no protect at 4300");
    supplyMv = 13'd4250; tick(DEB + 1);
    expProtected("R5 wide grade protect at 4250");
  endtask

  task automatic t_wide_seal();
    doReset(1'b1);
    supplyMv = 13'd2500; tick(20);
    expSealed("R2 wide grade low while sealed");
    supplyMv = 13'd4600; tick(DEB + 1);
    expNormal("R5 wide grade seal broken at 4600");
  endtask

  initial begin
    doReset(1'b0);
    t_seal_and_debounce();
    t_protect_band();
    t_glitch();
    t_backup();
    t_wide_grade();
    t_wide_seal();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule